// File: doc/BRIEF.md
# SMBus Clock Stretch and Bus Lockup Guard

This block sits beside the bit shifter of an SMBus or PMBus target and decides when the target may pull SCL low to gain time. The shifter's internal logic raises `busy` whenever it needs the host to wait. The guard only turns that request into an SCL hold at two legal points: right after the acknowledge clock (bit index 8) has fallen, or at the first SCL fall after a START has been flagged. A hold that lasts too long is cut off even if the request is still present. The guard never drives a clock edge. It can only keep SCL low.

A second job runs in parallel. Two timers measure how long SCL and SDA have each stayed low without a break. If either line stays low past the lockup limit, the guard pulses `abort` for one cycle and enters a released state. In that state `bus_release` tells the shifter to let go of both lines, and all bus activity is ignored. The guard leaves that state only when a STOP is flagged or when both lines are seen high together.

All timing counts a one-microsecond enable tick derived from the system clock frequency parameter. This makes the limits independent of the bus rate, so 100 kHz and 400 kHz traffic are both handled. The states are IDLE (watching), ARMED (a START was seen and the next SCL fall opens a window), WINDOW (a legal stretch point with SCL low), STRETCH (holding SCL low), and ABORTED (off the bus after a lockup). The transitions are:

- IDLE to ARMED on START.
- IDLE to WINDOW on an SCL fall while the bit index is 8.
- ARMED to WINDOW on an SCL fall.
- ARMED to IDLE on STOP.
- WINDOW to STRETCH when busy.
- WINDOW to IDLE when SCL reads high.
- STRETCH to IDLE when busy drops or the stretch limit is reached.
- Any non-ABORTED state to ABORTED on lockup.
- ABORTED to IDLE on STOP or when both lines are high.

Top module: `smb_stretch_guard`

## Requirements
- R1: After reset, `scl_hold`, `abort` and `bus_release` are all 0.
- R2: When SCL falls while `bit_idx` equals 8 and `busy` is 1, `scl_hold` is 1 no later than the second rising clock edge after the fall.
- R3: An SCL fall while `bit_idx` is not 8, with no START pending, never produces `scl_hold`, even with `busy` at 1.
- R4: After a `start_det` pulse, the next SCL fall opens a stretch point whatever `bit_idx` holds. With `busy` at 1, `scl_hold` follows as in R2.
- R5: While holding, `scl_hold` returns to 0 one clock after `busy` is sampled 0.
- R6: A single hold lasts at most STRETCH_US microseconds of ticks. It then ends with `busy` still 1, and it does not restart until the next legal point.
- R7: If SCL stays low for LOCK_US microseconds, `abort` is 1 for exactly one cycle. From the next cycle `bus_release` is 1 and `scl_hold` is 0.
- R8: If SDA stays low for LOCK_US microseconds, the same abort and release as in R7 happen.
- R9: While `bus_release` is 1, `busy`, `start_det`, `bit_idx` and SCL falls have no effect and `scl_hold` stays 0. `bus_release` returns to 0 when both lines read high or `stop_det` is 1.
- R10: A lockup that expires during a hold takes priority. `scl_hold` falls in the same cycle that `bus_release` rises, and the two are never 1 together.
- R11: A stretch point closes as soon as SCL reads high. A later `busy` raised before the next legal point does not produce a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized SCL line level |
| sda_in | input | 1 | Synchronized SDA line level |
| bit_idx | input | BIT_W | Bit position within the byte from the shifter; 8 marks the acknowledge bit |
| start_det | input | 1 | One-cycle pulse when a START condition is detected |
| stop_det | input | 1 | One-cycle pulse when a STOP condition is detected |
| busy | input | 1 | Target logic requests the host to wait |
| scl_hold | output | 1 | Pull SCL low (stretch) |
| abort | output | 1 | One-cycle pulse: current transaction aborted on lockup |
| bus_release | output | 1 | Target must release both lines and ignore the bus |

## Verification
The critical overlap is a lockup expiry that arrives while a stretch is in progress: ending the stretch and entering the released state then compete for the same cycle. The bench holds SDA low first, then opens an acknowledge-bit stretch so that the SDA timer expires partway through the hold while `busy` stays high. It then checks, cycle by cycle, that `scl_hold` was 1 just before the `abort` pulse, is 0 in the cycle after it, and that `bus_release` is 1 in that same cycle with no overlap.

// File: rtl/smb_guard_pkg.sv
package smb_guard_pkg;

    typedef enum logic [2:0] {
        G_IDLE    = 3'd0,
        G_ARMED   = 3'd1,
        G_WINDOW  = 3'd2,
        G_STRETCH = 3'd3,
        G_ABORTED = 3'd4
    } guard_state_t;

    localparam int unsigned US_PER_SEC = 1_000_000;

endpackage

// File: rtl/smb_us_tick.sv
module smb_us_tick #(
    parameter int unsigned DIV = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/smb_span_timer.sv
module smb_span_timer #(
    parameter int unsigned LIMIT = 25000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    output logic expired
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run)
            cnt <= '0;
        else if (tick && cnt != TOP)
            cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == TOP);
endmodule

// File: rtl/smb_stretch_guard.sv
module smb_stretch_guard
    import smb_guard_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned STRETCH_US = 25_000,
    parameter int unsigned LOCK_US    = 35_000,
    parameter int unsigned BIT_W      = 4,
    parameter int unsigned ACK_IDX    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [BIT_W-1:0] bit_idx,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             busy,
    output logic             scl_hold,
    output logic             abort,
    output logic             bus_release
);
    localparam int unsigned TICK_DIV = CLK_HZ / US_PER_SEC;
    localparam logic [BIT_W-1:0] ACK_CODE = BIT_W'(ACK_IDX);

    guard_state_t state, nxt;
    logic scl_q;
    logic scl_fall;
    logic tick;
    logic stretch_exp;
    logic [1:0] line_low;
    logic [1:0] line_exp;
    logic lock_hit;

    smb_us_tick #(.DIV(TICK_DIV)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    smb_span_timer #(.LIMIT(STRETCH_US)) u_stretch_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .run    (state == G_STRETCH),
        .expired(stretch_exp)
    );

    assign line_low = {~sda_in, ~scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_lock
        smb_span_timer #(.LIMIT(LOCK_US)) u_lock_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (tick),
            .run    (line_low[g]),
            .expired(line_exp[g])
        );
    end

    assign lock_hit = |line_exp;
    assign scl_fall = scl_q & ~scl_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            scl_q <= 1'b1;
        else
            scl_q <= scl_in;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            G_IDLE: begin
                if (start_det)
                    nxt = G_ARMED;
                else if (scl_fall && bit_idx == ACK_CODE)
                    nxt = G_WINDOW;
            end
            G_ARMED: begin
                if (stop_det)
                    nxt = G_IDLE;
                else if (scl_fall)
                    nxt = G_WINDOW;
            end
            G_WINDOW: begin
                if (scl_in)
                    nxt = G_IDLE;
                else if (busy)
                    nxt = G_STRETCH;
            end
            G_STRETCH: begin
                if (!busy || stretch_exp)
                    nxt = G_IDLE;
            end
            G_ABORTED: begin
                if (stop_det || (scl_in && sda_in))
                    nxt = G_IDLE;
            end
        endcase
        if (lock_hit && state != G_ABORTED)
            nxt = G_ABORTED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= G_IDLE;
        else
            state <= nxt;
    end

    always_comb begin
        scl_hold    = (state == G_STRETCH);
        bus_release = (state == G_ABORTED);
        abort       = lock_hit && (state != G_ABORTED);
    end
endmodule

// File: rtl/smb_guard_checker.sv
module smb_guard_checker #(
    parameter int unsigned CLK_HZ     = 100_000_000,
    parameter int unsigned STRETCH_US = 25_000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_in,
    input logic busy,
    input logic scl_hold,
    input logic abort,
    input logic bus_release
);
    localparam int unsigned HOLD_MAX = STRETCH_US * (CLK_HZ / 1_000_000) + 2;

    int unsigned hold_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            hold_run <= 0;
        else if (!scl_hold)
            hold_run <= 0;
        else if (hold_run <= HOLD_MAX)
            hold_run <= hold_run + 1;
    end

    assert_hold_opens_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_hold) |-> !$past(scl_in));

    assert_hold_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_hold |-> $past(busy));

    assert_hold_bounded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_run <= HOLD_MAX);

    assert_abort_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);

    assert_abort_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> bus_release);

    assert_release_after_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_release) |-> $past(abort));

    assert_hold_release_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_hold && bus_release));
endmodule

bind smb_stretch_guard smb_guard_checker #(
    .CLK_HZ    (CLK_HZ),
    .STRETCH_US(STRETCH_US)
) u_guard_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .busy       (busy),
    .scl_hold   (scl_hold),
    .abort      (abort),
    .bus_release(bus_release)
);

// File: tb/smb_stretch_guard_tb.sv
module smb_stretch_guard_tb;
    localparam int unsigned CLK_HZ     = 4_000_000;
    localparam int unsigned STRETCH_US = 25;
    localparam int unsigned LOCK_US    = 35;
    localparam int unsigned DIV        = CLK_HZ / 1_000_000;
    localparam int STRETCH_CYC = STRETCH_US * DIV;
    localparam int LOCK_CYC    = LOCK_US * DIV;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [3:0] bit_idx = 4'd0;
    logic start_det = 1'b0;
    logic stop_det = 1'b0;
    logic busy = 1'b0;
    logic scl_hold, abort, bus_release;
    logic scl_in, sda_in;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    assign scl_in = scl_m & ~scl_hold;
    assign sda_in = sda_m;

    always #5 clk = ~clk;

    smb_stretch_guard #(
        .CLK_HZ(CLK_HZ), .STRETCH_US(STRETCH_US), .LOCK_US(LOCK_US),
        .BIT_W(4), .ACK_IDX(8)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
        .bit_idx(bit_idx), .start_det(start_det), .stop_det(stop_det),
        .busy(busy), .scl_hold(scl_hold), .abort(abort), .bus_release(bus_release)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_bus();
        scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0; bit_idx = 4'd0;
        cyc(4);
    endtask

    task automatic t_reset();
        check(scl_hold == 0 && abort == 0 && bus_release == 0, "R1 reset outputs",
              {scl_hold, abort, bus_release}, 0);
    endtask

    task automatic t_ack_stretch();
        bit_idx = 4'd8; busy = 1'b1; scl_m = 1'b0;
        cyc(3);
        check(scl_hold == 1, "R2 hold after ack fall", scl_hold, 1);
        scl_m = 1'b1;
        cyc(10);
        check(scl_hold == 1 && scl_in == 0, "R2 SCL held low", scl_in, 0);
        busy = 1'b0;
        cyc(1);
        check(scl_hold == 0, "R5 release one clock after busy drops", scl_hold, 0);
        idle_bus();
    endtask

    task automatic t_wrong_bit();
        bit_idx = 4'd3; busy = 1'b1; scl_m = 1'b0;
        cyc(5);
        check(scl_hold == 0, "R3 no hold on data bit", scl_hold, 0);
        idle_bus();
    endtask

    task automatic t_start_stretch();
        bit_idx = 4'd5;
        start_det = 1'b1; cyc(1); start_det = 1'b0;
        cyc(2);
        busy = 1'b1; scl_m = 1'b0;
        cyc(3);
        check(scl_hold == 1, "R4 hold after START fall", scl_hold, 1);
        busy = 1'b0;
        cyc(2);
        idle_bus();
    endtask

    task automatic t_window_closes();
        bit_idx = 4'd8; busy = 1'b0; scl_m = 1'b0;
        cyc(3);
        scl_m = 1'b1; bit_idx = 4'd0;
        cyc(3);
        busy = 1'b1;
        cyc(3);
        check(scl_hold == 0, "R11 no hold after window closed (SCL high)", scl_hold, 0);
        scl_m = 1'b0;
        cyc(4);
        check(scl_hold == 0, "R11 no hold on next data fall", scl_hold, 0);
        idle_bus();
    endtask

    task automatic t_stretch_limit();
        int held = 0;
        bit_idx = 4'd8; busy = 1'b1; scl_m = 1'b0;
        cyc(3);
        scl_m = 1'b1;
        while (scl_hold && held < 1000) begin
            held++;
            cyc(1);
        end
        check(held >= STRETCH_CYC - 6 && held <= STRETCH_CYC + 2,
              "R6 hold duration capped", held, STRETCH_CYC);
        cyc(10);
        check(scl_hold == 0 && busy == 1, "R6 no restart while busy stays high", scl_hold, 0);
        idle_bus();
    endtask

    task automatic t_scl_lock();
        int waited = 0;
        bit_idx = 4'd3; scl_m = 1'b0;
        while (!abort && waited < 1000) begin
            waited++;
            cyc(1);
        end
        check(waited >= LOCK_CYC - 4 && waited <= LOCK_CYC + 4,
              "R7 SCL lockup time", waited, LOCK_CYC);
        cyc(1);
        check(abort == 0, "R7 abort one cycle", abort, 0);
        check(bus_release == 1 && scl_hold == 0, "R7 released", bus_release, 1);
        sda_m = 1'b0; scl_m = 1'b1;
        cyc(2);
        bit_idx = 4'd8; busy = 1'b1;
        start_det = 1'b1; cyc(1); start_det = 1'b0;
        scl_m = 1'b0;
        cyc(4);
        check(scl_hold == 0 && bus_release == 1, "R9 bus ignored while released", scl_hold, 0);
        scl_m = 1'b1; sda_m = 1'b1; busy = 1'b0;
        cyc(2);
        check(bus_release == 0, "R9 released state left on idle lines", bus_release, 0);
        idle_bus();
    endtask

    task automatic t_sda_lock();
        int waited = 0;
        sda_m = 1'b0;
        while (!abort && waited < 1000) begin
            waited++;
            cyc(1);
        end
        check(waited >= LOCK_CYC - 4 && waited <= LOCK_CYC + 4,
              "R8 SDA lockup time", waited, LOCK_CYC);
        cyc(1);
        check(bus_release == 1, "R8 released", bus_release, 1);
        sda_m = 1'b1;
        cyc(2);
        check(bus_release == 0, "R9 exit after SDA release", bus_release, 0);
        idle_bus();
    endtask

    task automatic t_lock_during_stretch();
        int waited = 0;
        bit prev_hold = 1'b0;
        sda_m = 1'b0;
        cyc(80);
        bit_idx = 4'd8; busy = 1'b1; scl_m = 1'b0;
        cyc(3);
        scl_m = 1'b1;
        check(scl_hold == 1, "R10 stretch active before lockup", scl_hold, 1);
        while (!abort && waited < 1000) begin
            prev_hold = scl_hold;
            waited++;
            cyc(1);
        end
        check(prev_hold == 1, "R10 hold active up to abort", prev_hold, 1);
        cyc(1);
        check(scl_hold == 0 && bus_release == 1, "R10 lockup wins over stretch",
              {scl_hold, bus_release}, 1);
        sda_m = 1'b1; busy = 1'b0;
        cyc(3);
        check(bus_release == 0, "R9 exit after collision", bus_release, 0);
        idle_bus();
    endtask

    initial begin
        cyc(3);
        t_reset();
        rst_n = 1'b1;
        cyc(3);
        t_reset();
        t_ack_stretch();
        t_wrong_bit();
        t_start_stretch();
        t_window_closes();
        t_stretch_limit();
        t_scl_lock();
        t_sda_lock();
        t_lock_during_stretch();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100_000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 100_000, 0);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule